// File: doc/BRIEF.md
# Per-Pin Interrupt Trigger and Status Logic

This block sits behind a bank of debounced input pins. For every pin it turns the filtered level into two sticky status bits. The interrupt status bit is recorded while that pin's interrupt enable is set. The wake status bit is recorded while the system is in a sleep state that the pin has been allowed to wake. Per pin, the trigger is either level sensitive or edge sensitive. A 2-bit polarity code picks the active level or edge.

Software clears either status bit by writing 1 to it. The register decoder turns that write into a one-cycle clear pulse. A separate unmask bit per pin decides whether a recorded status is offered to the downstream aggregator as pending. Enable therefore governs recording, and unmask governs delivery.

The debounce filter and the register bus are outside this block. It receives the filtered pin levels, the configuration fields and the clear pulses as plain signals.

Top module: `pin_irq_status`

## Requirements
- R1: While `rstN` is low, and until the first trigger after it rises, every status, pending and `anyPending` output is 0.
- R2: In edge mode (`cfgLevelMode`=0) with polarity code 2'b00, a pin whose level goes from 0 to 1 between two rising clock edges has its status set after the second of those edges. A 1-to-0 change sets nothing.
- R3: In edge mode with polarity code 2'b01, only a 1-to-0 change of the pin level sets status.
- R4: In edge mode with polarity code 2'b10, a change in either direction sets status. Code 2'b11 never triggers in edge mode.
- R5: In level mode (`cfgLevelMode`=1), code 2'b00 sets status on every clock edge at which the pin is 1, and code 2'b01 sets it on every edge at which the pin is 0. Codes 2'b10 and 2'b11 never trigger in level mode.
- R6: A pin's interrupt status bit is only set by a trigger at an edge where that pin's `cfgIntEn` bit is 1. Otherwise the bit keeps its value.
- R7: A 1 on `clrIntStatus[p]` or `clrWakeStatus[p]` at a clock edge clears the matching bit at that edge. A clear takes priority over a trigger at the same edge. A level trigger that is still active sets the bit again at the following edge.
- R8: `sleepState` encodes 0 awake, 1 light idle, 2 standby and 3 off. At a trigger while `sleepState` is n (1 to 3), the wake status of pin p is set if `cfgWakeEn[3*p+n-1]` is 1. This holds regardless of `cfgIntEn`. No wake status is set while awake.
- R9: `pinPending[p]` is (`intStatus[p]` or `wakeStatus[p]`) and `cfgIntUnmask[p]`. `anyPending` is the OR of all `pinPending` bits.
- R10: No edge is detected at the first clock edge after reset, whatever the pin levels are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinLevel | input | NUM_PINS | Debounced pin levels |
| cfgLevelMode | input | NUM_PINS | 1 = level trigger, 0 = edge trigger |
| cfgActive | input | 2*NUM_PINS | Polarity code per pin, pin p at bits [2p+1:2p] |
| cfgIntEn | input | NUM_PINS | Interrupt status recording enable |
| cfgIntUnmask | input | NUM_PINS | 1 = status offered as pending |
| cfgWakeEn | input | 3*NUM_PINS | Wake enables per sleep state, pin p at bits [3p+2:3p] |
| sleepState | input | 2 | Current system sleep state |
| clrIntStatus | input | NUM_PINS | Write-1 clear pulses for interrupt status |
| clrWakeStatus | input | NUM_PINS | Write-1 clear pulses for wake status |
| intStatus | output | NUM_PINS | Sticky interrupt status |
| wakeStatus | output | NUM_PINS | Sticky wake status |
| pinPending | output | NUM_PINS | Per-pin pending to the aggregator |
| anyPending | output | 1 | OR of all pending bits |

## Verification
The bench goes after the edge detector's first cycle after reset. A design without a primed previous-level register would report a false rising edge on a pin held high through reset.

It also clears a status bit while a level trigger is still active. A design that lets the trigger win shows no one-cycle gap. A design that drops the re-arm leaves the bit low.

Wake stimulus runs with interrupt enable off and walks every sleep state. This exposes a design that gates wake recording on interrupt enable or decodes the wake-enable bit off by one state.

Toggling unmask on pins that hold status shows whether pending follows the mask while the sticky status stays untouched.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  typedef enum logic [1:0] {
    ACT_HIGH = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_BOTH = 2'b10,
    ACT_NONE = 2'b11
  } actCode_t;

  typedef enum logic [1:0] {
    SLP_AWAKE   = 2'd0,
    SLP_IDLE    = 2'd1,
    SLP_STANDBY = 2'd2,
    SLP_OFF     = 2'd3
  } sleepCode_t;

  localparam int WAKE_STATES = 3;

  typedef struct packed {
    logic setInt;
    logic setWake;
    logic clrInt;
    logic clrWake;
  } pinStrobe_t;

endpackage

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_PINS-1:0]               pinLevel,
  input  logic [NUM_PINS-1:0]               cfgLevelMode,
  input  logic [2*NUM_PINS-1:0]             cfgActive,
  input  logic [NUM_PINS-1:0]               cfgIntEn,
  input  logic [WAKE_STATES*NUM_PINS-1:0]   cfgWakeEn,
  input  logic [1:0]                        sleepState,
  input  logic [NUM_PINS-1:0]               clrIntStatus,
  input  logic [NUM_PINS-1:0]               clrWakeStatus,
  output pinStrobe_t [NUM_PINS-1:0]         strb
);

  logic [NUM_PINS-1:0] prevLevel;
  logic                prevValid;

  // prevValid primes the edge detector so reset values never look like edges
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevLevel <= '0;
      prevValid <= 1'b0;
    end else begin
      prevLevel <= pinLevel;
      prevValid <= 1'b1;
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [1:0] code;
    logic       rise, fall, hit, wakeArm;

    assign code = cfgActive[2*p +: 2];
    assign rise = prevValid &  pinLevel[p] & ~prevLevel[p];
    assign fall = prevValid & ~pinLevel[p] &  prevLevel[p];

    always_comb begin
      hit = 1'b0;
      if (cfgLevelMode[p]) begin
        if (code == ACT_HIGH)     hit = pinLevel[p];
        else if (code == ACT_LOW) hit = ~pinLevel[p];
      end else begin
        case (code)
          ACT_HIGH: hit = rise;
          ACT_LOW:  hit = fall;
          ACT_BOTH: hit = rise | fall;
          default:  hit = 1'b0;
        endcase
      end
    end

    always_comb begin
      case (sleepState)
        SLP_IDLE:    wakeArm = cfgWakeEn[WAKE_STATES*p];
        SLP_STANDBY: wakeArm = cfgWakeEn[WAKE_STATES*p + 1];
        SLP_OFF:     wakeArm = cfgWakeEn[WAKE_STATES*p + 2];
        default:     wakeArm = 1'b0;
      endcase
    end

    assign strb[p].setInt  = hit & cfgIntEn[p];
    assign strb[p].setWake = hit & wakeArm;
    assign strb[p].clrInt  = clrIntStatus[p];
    assign strb[p].clrWake = clrWakeStatus[p];
  end

endmodule

// File: rtl/pin_irq_dp.sv
module pin_irq_dp
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  pinStrobe_t [NUM_PINS-1:0] strb,
  input  logic [NUM_PINS-1:0]       cfgIntUnmask,
  output logic [NUM_PINS-1:0]       intStatus,
  output logic [NUM_PINS-1:0]       wakeStatus,
  output logic [NUM_PINS-1:0]       pinPending,
  output logic                      anyPending
);

  logic [NUM_PINS-1:0] setIntVec, setWakeVec, clrIntVec, clrWakeVec;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_unpack
    assign setIntVec[p]  = strb[p].setInt;
    assign setWakeVec[p] = strb[p].setWake;
    assign clrIntVec[p]  = strb[p].clrInt;
    assign clrWakeVec[p] = strb[p].clrWake;
  end

  // clear beats set at the same edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      intStatus  <= '0;
      wakeStatus <= '0;
    end else begin
      intStatus  <= (intStatus  | setIntVec)  & ~clrIntVec;
      wakeStatus <= (wakeStatus | setWakeVec) & ~clrWakeVec;
    end
  end

  assign pinPending = (intStatus | wakeStatus) & cfgIntUnmask;
  assign anyPending = |pinPending;

  // R7
  clrWins_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) |-> (((intStatus & $past(clrIntVec)) == '0) &&
                      ((wakeStatus & $past(clrWakeVec)) == '0))));

  // R7
  setOnlyByStrobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) |-> ((intStatus & ~$past(intStatus) & ~$past(setIntVec)) == '0)));

endmodule

// File: rtl/pin_irq_status.sv
module pin_irq_status
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_PINS-1:0]             pinLevel,
  input  logic [NUM_PINS-1:0]             cfgLevelMode,
  input  logic [2*NUM_PINS-1:0]           cfgActive,
  input  logic [NUM_PINS-1:0]             cfgIntEn,
  input  logic [NUM_PINS-1:0]             cfgIntUnmask,
  input  logic [WAKE_STATES*NUM_PINS-1:0] cfgWakeEn,
  input  logic [1:0]                      sleepState,
  input  logic [NUM_PINS-1:0]             clrIntStatus,
  input  logic [NUM_PINS-1:0]             clrWakeStatus,
  output logic [NUM_PINS-1:0]             intStatus,
  output logic [NUM_PINS-1:0]             wakeStatus,
  output logic [NUM_PINS-1:0]             pinPending,
  output logic                            anyPending
);

  pinStrobe_t [NUM_PINS-1:0] strb;

  pin_irq_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
    .clk(clk), .rstN(rstN), .pinLevel(pinLevel), .cfgLevelMode(cfgLevelMode),
    .cfgActive(cfgActive), .cfgIntEn(cfgIntEn), .cfgWakeEn(cfgWakeEn),
    .sleepState(sleepState), .clrIntStatus(clrIntStatus),
    .clrWakeStatus(clrWakeStatus), .strb(strb)
  );

  pin_irq_dp #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgIntUnmask(cfgIntUnmask),
    .intStatus(intStatus), .wakeStatus(wakeStatus),
    .pinPending(pinPending), .anyPending(anyPending)
  );

  // R6
  intGate_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) |-> ((intStatus & ~$past(intStatus) & ~$past(cfgIntEn)) == '0)));

  // R8
  wakeAwake_chk: assert property (@(posedge clk) disable iff (!rstN)
    (($past(rstN) && ($past(sleepState) == SLP_AWAKE)) |->
      ((wakeStatus & ~$past(wakeStatus)) == '0)));

  // R10
  edgeNeedsChange_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) |->
      ((((intStatus & ~$past(intStatus)) | (wakeStatus & ~$past(wakeStatus))) &
        ~$past(cfgLevelMode) & ~($past(pinLevel) ^ $past(pinLevel, 2))) == '0)));

  // R9
  pendingMask_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pinPending & ~cfgIntUnmask) == '0));

endmodule

// File: tb/pin_irq_status_bench.sv
`timescale 1ns/1ps
module pin_irq_status_bench;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0]   pinLevel = '0, cfgLevelMode = '0, cfgIntEn = '0, cfgIntUnmask = '0;
  logic [2*N-1:0] cfgActive = '0;
  logic [3*N-1:0] cfgWakeEn = '0;
  logic [1:0]     sleepState = 2'd0;
  logic [N-1:0]   clrIntStatus = '0, clrWakeStatus = '0;
  logic [N-1:0]   intStatus, wakeStatus, pinPending;
  logic           anyPending;

  always #4 clk = ~clk;

  pin_irq_status #(.NUM_PINS(N)) u_pin_irq_status (
    .clk(clk), .rstN(rstN), .pinLevel(pinLevel), .cfgLevelMode(cfgLevelMode),
    .cfgActive(cfgActive), .cfgIntEn(cfgIntEn), .cfgIntUnmask(cfgIntUnmask),
    .cfgWakeEn(cfgWakeEn), .sleepState(sleepState), .clrIntStatus(clrIntStatus),
    .clrWakeStatus(clrWakeStatus), .intStatus(intStatus), .wakeStatus(wakeStatus),
    .pinPending(pinPending), .anyPending(anyPending)
  );

  int tests = 0;
  int fails = 0;
  string curReq = "R1";

  // behavioural reference model
  bit mInt[N];
  bit mWake[N];
  bit mPrev[N];
  bit mValid;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < N; p++) begin
        mInt[p] = 0; mWake[p] = 0; mPrev[p] = 0;
      end
      mValid = 0;
    end else begin
      for (int p = 0; p < N; p++) begin
        int code;
        bit lvl, rise, fall, trig, wk;
        lvl  = pinLevel[p];
        code = int'(cfgActive[2*p +: 2]);
        rise = mValid && lvl && !mPrev[p];
        fall = mValid && !lvl && mPrev[p];
        if (cfgLevelMode[p]) trig = (code == 0 && lvl) || (code == 1 && !lvl);
        else trig = (code == 0 && rise) || (code == 1 && fall) || (code == 2 && (rise || fall));
        wk = (sleepState != 0) && cfgWakeEn[3*p + int'(sleepState) - 1];
        if (clrIntStatus[p]) mInt[p] = 0;
        else if (trig && cfgIntEn[p]) mInt[p] = 1;
        if (clrWakeStatus[p]) mWake[p] = 0;
        else if (trig && wk) mWake[p] = 1;
        mPrev[p] = lvl;
      end
      mValid = 1;
    end
  end

  task automatic compare();
    logic [N-1:0] eI, eW, eP;
    logic eA;
    for (int p = 0; p < N; p++) begin
      eI[p] = mInt[p];
      eW[p] = mWake[p];
      eP[p] = (mInt[p] | mWake[p]) & cfgIntUnmask[p];
    end
    eA = |eP;
    tests++;
    if (intStatus !== eI || wakeStatus !== eW || pinPending !== eP || anyPending !== eA) begin
      fails++;
      $display("FAIL %s: int=%b wake=%b pend=%b any=%b expected int=%b wake=%b pend=%b any=%b",
               curReq, intStatus, wakeStatus, pinPending, anyPending, eI, eW, eP, eA);
    end
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic setLevels(input logic [N-1:0] v);
    pinLevel = v;
    step();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    curReq = "R1";
    cfgIntEn = '1; cfgIntUnmask = '1;
    repeat (3) step();
    @(negedge clk); rstN = 1'b1;
    step();

    // R2/R3/R4: edge mode, p0 rising, p1 falling, p2 both, p3 none
    cfgLevelMode = '0;
    cfgActive = {2'b11, 2'b10, 2'b01, 2'b00};
    curReq = "R2";
    setLevels(4'b1111); setLevels(4'b1111);
    curReq = "R3";
    setLevels(4'b0000); setLevels(4'b0000);
    clrIntStatus = '1; step(); clrIntStatus = '0;
    curReq = "R4";
    setLevels(4'b0101); setLevels(4'b1010); setLevels(4'b1010);
    clrIntStatus = '1; step(); clrIntStatus = '0;
    curReq = "R2";
    setLevels(4'b0000); setLevels(4'b0001); setLevels(4'b0000); setLevels(4'b0001);

    // R7: clear while edge arrives at same edge -> clear wins
    curReq = "R7";
    clrIntStatus = '1; pinLevel = 4'b0110; step(); clrIntStatus = '0;
    step();

    // R5: level mode
    curReq = "R5";
    cfgLevelMode = '1;
    cfgActive = {2'b11, 2'b10, 2'b01, 2'b00};
    clrIntStatus = '1; pinLevel = 4'b0000; step(); clrIntStatus = '0;
    setLevels(4'b0000); setLevels(4'b1111); setLevels(4'b1111);
    // R7: clear while level still active: gap then re-set
    curReq = "R7";
    clrIntStatus = 4'b0001; step(); clrIntStatus = '0;
    step(); step();
    pinLevel = 4'b1110; clrIntStatus = '1; step(); clrIntStatus = '0;
    step(); step();

    // R6: interrupt enable off
    curReq = "R6";
    clrIntStatus = '1; cfgIntEn = '0; step(); clrIntStatus = '0;
    setLevels(4'b0001); setLevels(4'b0010); setLevels(4'b0000);
    cfgIntEn = 4'b0010; setLevels(4'b0011);
    cfgIntEn = '1;

    // R9: mask toggling on held status
    curReq = "R9";
    cfgIntUnmask = 4'b0000; step();
    cfgIntUnmask = 4'b0101; step();
    cfgIntUnmask = 4'b1010; step();
    cfgIntUnmask = '1; step();

    // R8: wake with interrupts disabled, walking sleep states
    curReq = "R8";
    cfgIntEn = '0; clrIntStatus = '1; clrWakeStatus = '1; cfgLevelMode = '0;
    cfgActive = {2'b10, 2'b10, 2'b10, 2'b10}; pinLevel = '0; step();
    clrIntStatus = '0; clrWakeStatus = '0;
    cfgWakeEn = 12'b100_010_001_111;
    for (int s = 0; s < 4; s++) begin
      sleepState = 2'(s);
      setLevels(4'b1111); setLevels(4'b0000);
      clrWakeStatus = '1; step(); clrWakeStatus = '0;
    end
    sleepState = 2'd2; setLevels(4'b1111);
    clrWakeStatus = 4'b0100; step(); clrWakeStatus = '0;
    sleepState = 2'd0; cfgIntEn = '1;

    // R9: pseudo-random mixed traffic
    curReq = "R9";
    begin
      logic [31:0] lfsr = 32'h1ACE_B00C;
      for (int i = 0; i < 400; i++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        pinLevel      = lfsr[3:0];
        if (i % 16 == 0) begin
          cfgLevelMode = lfsr[7:4]; cfgActive = lfsr[15:8];
          cfgIntEn = lfsr[19:16]; cfgWakeEn = lfsr[31:20];
        end
        cfgIntUnmask  = lfsr[11:8] | lfsr[27:24];
        sleepState    = lfsr[13:12];
        clrIntStatus  = lfsr[17:14] & lfsr[21:18] & lfsr[25:22];
        clrWakeStatus = lfsr[29:26] & lfsr[9:6] & lfsr[5:2];
        step();
      end
    end
    clrIntStatus = '0; clrWakeStatus = '0;

    // R10: pin held high across reset, rising-edge mode
    curReq = "R10";
    cfgLevelMode = '0; cfgActive = '0; cfgIntEn = '1; cfgWakeEn = '1;
    sleepState = 2'd3; cfgIntUnmask = '1; pinLevel = '1;
    rstN = 1'b0; step(); step();
    rstN = 1'b1; step(); step(); step();
    setLevels(4'b0000); setLevels(4'b0011); step();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule